// File: doc/BRIEF.md
# USB Suspend and Wake-Up Detector

This block observes a decoded line-idle indication from a USB device front end and turns it into two interrupt flags: a suspend flag, raised once the bus has been idle without a break for three milliseconds, and a wake-up flag, raised when bus activity reappears after an idle sample. Raising either flag clears the other. Firmware can clear each flag through a strobe. A firmware-owned freeze-clock bit is held here so that firmware can stop the controller clock while suspended and release it after wake-up.

The block also guards upstream resume signalling. A firmware remote wake-up request is honoured only when a suspend has been flagged since the last wake-up event and the host has granted remote-wakeup permission. An honoured request drives the resume enable for a programmable number of milliseconds, then the enable drops by itself. A refused request starts nothing and sets a sticky error bit.

Millisecond timing comes from the parameter `CYC_PER_MS`, the number of block clock cycles in one millisecond. The resume length in milliseconds is set by `RESUME_MS`.

Top module: `usb_susp_wake`

## Requirements
- R1: The suspend flag is 1 after the clock edge that samples the (3 × CYC_PER_MS)-th consecutive cycle with `line_idle` = 1, and not before that edge.
- R2: The suspend flag is raised at most once for each unbroken idle stretch. Any sample with `line_idle` = 0 restarts the idle count from zero.
- R3: The wake-up flag is set on the edge that samples `line_idle` = 0 when the previous sample was 1. This holds whether or not the suspend flag is set. After reset the previous sample counts as not idle.
- R4: Raising the suspend flag clears the wake-up flag, and raising the wake-up flag clears the suspend flag. The two flags are never 1 together.
- R5: A 1 on `susp_clr` or `wake_clr` clears that flag on the next edge. When the same flag's hardware set event occurs in that cycle, the flag stays set.
- R6: `frz_set` sets `frz_clk` and `frz_clr` clears it on the next edge. When both are 1, the bit ends up set.
- R7: A `rwu_req` pulse is accepted only if a suspend flag was raised after the last wake-up event and no accepted request has used it since, and `rwu_allowed` = 1 in the same cycle.
- R8: An accepted request sets `resume_drive` on the accepting edge. It stays 1 for exactly RESUME_MS × CYC_PER_MS cycles, then returns to 0 with no further action.
- R9: A request that is not accepted leaves `resume_drive` unchanged. It sets `rwu_err`, which stays 1 until reset.
- R10: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_idle | input | 1 | 1 while the decoded bus state is idle, already in the clk domain |
| rwu_allowed | input | 1 | Host has granted remote-wakeup permission |
| susp_clr | input | 1 | Firmware strobe clearing the suspend flag |
| wake_clr | input | 1 | Firmware strobe clearing the wake-up flag |
| frz_set | input | 1 | Firmware strobe setting the freeze-clock bit |
| frz_clr | input | 1 | Firmware strobe clearing the freeze-clock bit |
| rwu_req | input | 1 | Firmware remote wake-up request strobe |
| susp_flag | output | 1 | Suspend interrupt flag |
| wake_flag | output | 1 | Wake-up interrupt flag |
| frz_clk | output | 1 | Freeze-clock control bit |
| resume_drive | output | 1 | Enable for upstream resume signalling |
| rwu_err | output | 1 | Sticky refused-request indicator |

## Verification
Every result appears at the first clock edge that samples its cause. The suspend flag follows the edge that samples the last required idle cycle. The wake-up flag follows the edge that samples the first active cycle. Flag clears, freeze-bit updates, the error bit and the start of resume drive all follow the edge that samples their strobe. The bench drives inputs on the falling edge, lets one rising edge pass for each applied cycle, and compares outputs on the next falling edge. A vector held for N cycles is therefore checked exactly after its N-th sampling edge. The resume window is confirmed by observing `resume_drive` on each of its cycles and on the one after.

// File: rtl/usw_pkg.sv
// Shared constants for the suspend and wake-up detector.
// Assumes nothing beyond a synthesizable integer context.
package usw_pkg;
    // Idle time before a suspend is flagged, in milliseconds.
    localparam int unsigned SUSP_IDLE_MS = 3;

    // Width that holds values 0..limit inclusive.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/usw_idle_timer.sv
// Counts consecutive idle samples and reports a suspend event on the
// sample that completes the idle window, once per idle stretch. It also
// reports the idle-to-active transition used as the wake-up event.
// Assumes line_idle is already synchronous to clk.
module usw_idle_timer
    import usw_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    output logic susp_evt,
    output logic wake_evt
);
    localparam int unsigned LIMIT = SUSP_IDLE_MS * CYC_PER_MS;
    localparam int unsigned CW    = cnt_width(LIMIT);

    logic [CW-1:0] idle_cnt;
    logic          fired;
    logic          prev_idle;

    // Event decode from the current sample and the held state.
    always_comb begin
        susp_evt = line_idle && !fired && (idle_cnt == CW'(LIMIT - 1));
        wake_evt = prev_idle && !line_idle;
    end

    // Idle counter: restart on activity, stop once the event has fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            fired    <= 1'b0;
        end else if (!line_idle) begin
            idle_cnt <= '0;
            fired    <= 1'b0;
        end else if (susp_evt) begin
            fired    <= 1'b1;
        end else if (!fired) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Previous-sample register for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_idle <= 1'b0;
        else        prev_idle <= line_idle;
    end
endmodule

// File: rtl/usw_flag.sv
// One set/clear flag bit where a set in the same cycle beats a clear.
// Assumes set_i and clr_i are single-cycle or level requests in clk domain.
module usw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Flag state with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/usw_resume.sv
// Gates firmware remote wake-up requests and times the resume drive.
// A suspend event arms the gate, a wake-up event or an accepted request
// disarms it. Refused requests set a sticky error bit.
// Assumes RESUME_MS * CYC_PER_MS >= 1.
module usw_resume
    import usw_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 48000,
    parameter int unsigned RESUME_MS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_evt,
    input  logic wake_evt,
    input  logic req,
    input  logic allowed,
    output logic drive,
    output logic err
);
    localparam int unsigned DRV_LEN = RESUME_MS * CYC_PER_MS;
    localparam int unsigned DW      = cnt_width(DRV_LEN);

    logic          armed;
    logic          accept;
    logic [DW-1:0] drv_cnt;

    // Acceptance decode.
    always_comb accept = req && armed && allowed;

    // Arm state: suspend arms, wake-up or acceptance disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (wake_evt || accept) armed <= 1'b0;
        else if (susp_evt)           armed <= 1'b1;
    end

    // Resume window timer: start on acceptance, end after DRV_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive   <= 1'b0;
            drv_cnt <= '0;
        end else if (accept) begin
            drive   <= 1'b1;
            drv_cnt <= '0;
        end else if (drive) begin
            if (drv_cnt == DW'(DRV_LEN - 1)) drive <= 1'b0;
            else                             drv_cnt <= drv_cnt + 1'b1;
        end
    end

    // Sticky refusal indicator.
    always_ff @(posedge clk) begin
        if (!rst_n)             err <= 1'b0;
        else if (req && !accept) err <= 1'b1;
    end
endmodule

// File: rtl/usb_susp_wake.sv
// Top level: suspend and wake-up interrupt flags, freeze-clock bit and
// remote wake-up gating. Assumes all inputs are synchronous to clk.
module usb_susp_wake #(
    parameter int unsigned CYC_PER_MS = 48000,
    parameter int unsigned RESUME_MS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    input  logic rwu_allowed,
    input  logic susp_clr,
    input  logic wake_clr,
    input  logic frz_set,
    input  logic frz_clr,
    input  logic rwu_req,
    output logic susp_flag,
    output logic wake_flag,
    output logic frz_clk,
    output logic resume_drive,
    output logic rwu_err
);
    logic susp_evt;
    logic wake_evt;

    usw_idle_timer #(.CYC_PER_MS(CYC_PER_MS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_idle(line_idle),
        .susp_evt (susp_evt),
        .wake_evt (wake_evt)
    );

    // Each interrupt flag is cleared by firmware or by the other's event.
    usw_flag u_susp (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(susp_evt),
        .clr_i(susp_clr || wake_evt),
        .q    (susp_flag)
    );

    usw_flag u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(wake_evt),
        .clr_i(wake_clr || susp_evt),
        .q    (wake_flag)
    );

    usw_flag u_frz (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(frz_set),
        .clr_i(frz_clr),
        .q    (frz_clk)
    );

    usw_resume #(.CYC_PER_MS(CYC_PER_MS), .RESUME_MS(RESUME_MS)) u_rsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .susp_evt(susp_evt),
        .wake_evt(wake_evt),
        .req     (rwu_req),
        .allowed (rwu_allowed),
        .drive   (resume_drive),
        .err     (rwu_err)
    );
endmodule

// File: rtl/usb_susp_wake_chk.sv
// Property checker for usb_susp_wake, attached by bind below.
// Keeps its own previous-sample and window counters.
module usb_susp_wake_chk #(
    parameter int unsigned CYC_PER_MS = 48000,
    parameter int unsigned RESUME_MS  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic line_idle,
    input logic rwu_allowed,
    input logic susp_clr,
    input logic wake_clr,
    input logic frz_set,
    input logic frz_clr,
    input logic rwu_req,
    input logic susp_flag,
    input logic wake_flag,
    input logic frz_clk,
    input logic resume_drive,
    input logic rwu_err
);
    localparam int unsigned WIN = RESUME_MS * CYC_PER_MS;

    logic        seen_idle;
    int unsigned drv_run;

    // Previous line sample, not idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_idle <= 1'b0;
        else        seen_idle <= line_idle;
    end

    // Length of the current resume-drive run.
    always_ff @(posedge clk) begin
        if (!rst_n)            drv_run <= 0;
        else if (resume_drive) drv_run <= drv_run + 1;
        else                   drv_run <= 0;
    end

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(susp_flag && wake_flag));

    assert_wake_on_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_idle && !line_idle) |=> wake_flag);

    assert_frz_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frz_set |=> frz_clk);

    assert_drive_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!resume_drive && !(rwu_req && rwu_allowed)) |=> !$rose(resume_drive));

    assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_run <= WIN);

    assert_refusal_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rwu_req && !rwu_allowed) |=> rwu_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rwu_err |=> rwu_err);
endmodule

bind usb_susp_wake usb_susp_wake_chk #(
    .CYC_PER_MS(CYC_PER_MS),
    .RESUME_MS (RESUME_MS)
) u_chk (.*);

// File: tb/usb_susp_wake_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset and corner cases. CYC_PER_MS = 4 so suspend needs 12
// idle samples and the resume window is 8 cycles.
module usb_susp_wake_bench;
    localparam int unsigned CPM  = 4;
    localparam int unsigned RMS  = 2;
    localparam int unsigned IDLE = 3 * CPM;
    localparam int unsigned WIN  = RMS * CPM;
    localparam int          NV   = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_idle = 1'b0, rwu_allowed = 1'b0, susp_clr = 1'b0, wake_clr = 1'b0;
    logic frz_set = 1'b0, frz_clr = 1'b0, rwu_req = 1'b0;
    logic susp_flag, wake_flag, frz_clk, resume_drive, rwu_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    usb_susp_wake #(.CYC_PER_MS(CPM), .RESUME_MS(RMS)) u_usb_susp_wake (.*);

    // Vector: {reps[7:0], req_tag[3:0], in[6:0], exp[4:0]}
    // in  = {idle, allowed, susp_clr, wake_clr, frz_set, frz_clr, rwu_req}
    // exp = {susp_flag, wake_flag, frz_clk, resume_drive, rwu_err}
    localparam logic [23:0] VEC [0:NV-1] = '{
        {8'd2,  4'd10, 7'b0000000, 5'b00000}, // R10 active bus, no wake yet
        {8'd11, 4'd1,  7'b1000000, 5'b00000}, // R1 one short of window
        {8'd1,  4'd1,  7'b1000000, 5'b10000}, // R1 suspend flagged
        {8'd20, 4'd2,  7'b1000000, 5'b10000}, // R2 held idle
        {8'd1,  4'd5,  7'b1010000, 5'b00000}, // R5 firmware clear
        {8'd10, 4'd2,  7'b1000000, 5'b00000}, // R2 no second suspend
        {8'd1,  4'd3,  7'b0000000, 5'b01000}, // R3 wake while not suspended
        {8'd1,  4'd9,  7'b0100001, 5'b01001}, // R9 disarmed by wake: refused
        {8'd1,  4'd6,  7'b0001100, 5'b00101}, // R6 freeze set, R5 wake clear
        {8'd1,  4'd6,  7'b0000110, 5'b00101}, // R6 set beats clear
        {8'd1,  4'd6,  7'b0000010, 5'b00001}, // R6 clear
        {8'd12, 4'd1,  7'b1000000, 5'b10001}, // R1 fresh idle window
        {8'd1,  4'd9,  7'b1000001, 5'b10001}, // R9 no permission: no drive
        {8'd1,  4'd7,  7'b1100001, 5'b10011}, // R7 accepted
        {8'd7,  4'd8,  7'b1100000, 5'b10011}, // R8 rest of window
        {8'd1,  4'd8,  7'b1000000, 5'b10001}, // R8 drive ends
        {8'd1,  4'd4,  7'b0000000, 5'b01001}, // R4 wake clears suspend
        {8'd12, 4'd4,  7'b1000000, 5'b10001}  // R4 suspend clears wake
    };

    function automatic logic [4:0] outs();
        return {susp_flag, wake_flag, frz_clk, resume_drive, rwu_err};
    endfunction

    task automatic check(input string tag, input logic [4:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    task automatic apply(input logic [6:0] in, input int reps);
        {line_idle, rwu_allowed, susp_clr, wake_clr, frz_set, frz_clr, rwu_req} = in;
        for (int k = 0; k < reps; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", 5'b00000);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][11:5], int'(VEC[v][23:16]));
            check($sformatf("R%0d vec%0d", VEC[v][15:12], v), VEC[v][4:0]);
        end

        // R10: reset from a busy state returns every output to zero.
        rst_n = 1'b0;
        apply(7'b0000000, 2);
        check("R10", 5'b00000);
        rst_n = 1'b1;

        // R5: firmware clear on the completing idle sample loses to the set.
        apply(7'b1000000, IDLE - 1);
        apply(7'b1010000, 1);
        check("R5 suspend set beats clear", 5'b10000);

        // R5 and R4: wake set beats clear and removes suspend.
        apply(7'b0001000, 1);
        check("R5 wake set beats clear", 5'b01000);

        // R9: armed but not permitted is refused and flagged.
        apply(7'b1000000, IDLE);
        check("R1 directed", 5'b10000);
        apply(7'b1000001, 1);
        check("R9 refused", 5'b10001);

        // R7 and R8: permitted request drives for exactly WIN cycles.
        apply(7'b1100001, 1);
        check("R7 accepted", 5'b10011);
        for (int c = 1; c < WIN; c++) begin
            apply(7'b1000000, 1);
            check("R8 window", 5'b10011);
        end
        apply(7'b1000000, 1);
        check("R8 window end", 5'b10001);

        // R7: the suspend was consumed, a second request is refused.
        apply(7'b1100001, 1);
        check("R7 single use", 5'b10001);

        finish_run();
    end
endmodule